// File: doc/BRIEF.md
# Self-Test Pattern Checker with Word Alignment

This block sits behind a serial receiver's deserialiser and judges whether the parallel words it delivers carry a known self-test pattern. It supports three patterns: a short pseudo-random sequence from an 8-stage shift register, a longer one from a 10-stage shift register, and a repeating list of decoded control and data bytes. The checker cannot judge data until it has found its place in the stream. It therefore first hunts for a mode-specific marker at every bit offset of the incoming words. When it finds the marker, it freezes that offset and raises its lock flag.

Once locked, the checker builds a local reference. In the pseudo-random modes, it loads the first aligned word after the marker into its shift register and then lets the register run free. In the byte-list mode, it restarts its list position just past the sync character. Every later aligned word is compared with the reference. Each word that differs produces a one-cycle error flag and one step of a saturating error count. A run of sixteen bad words in a row drops lock and starts a fresh search.

Words arrive on a valid/ready stream. The checker never applies back-pressure: `in_ready` is always 1, and a word is taken on every clock edge where `in_valid` is 1. The mode and clear inputs are plain control pins. The mode must stay constant between resets.

Top module: `bist_pattern_checker`

## Requirements
- R1: `in_ready` is always 1. On an edge where `in_valid` is 0, the word input is ignored: lock, the reference position and the count are unchanged, and `err_pulse` is 0 in the following cycle.
- R2: After reset, `locked`, `err_pulse` and `err_count` are all 0.
- R3: With `mode` = 0, the stream is read with bit 0 of each word first. The checker locks on the 16-bit marker 1, then seven 0s, then eight 1s, starting at any bit offset. If the marker's first bit lies in word k (counting accepted words from 0 after reset), `locked` rises at the edge that accepts word k+2.
- R4: With `mode` = 1, the marker is ten consecutive 1s, found at any bit offset, with the same k+2 timing as R3.
- R5: In both shift-register modes, aligned word j is the W stream bits that start j·W bits after the marker's last bit. Aligned word 0 is the seed. Each later aligned word is compared with the continuation of the seed under the recurrence s[n]=s[n-1]^s[n-3]^s[n-5]^s[n-8] (mode 0) or s[n]=s[n-3]^s[n-10] (mode 1). A stream that obeys the recurrence gives no errors. An aligned word whose first bit lies in input word k is judged at the edge that accepts word k+2.
- R6: With `mode` = 2 or 3, bit 8 of a word is the control flag and bits 7:0 are the byte. `locked` rises at the edge that accepts the sync word {1, 0xBC}. The words that follow are compared with a list of 268 entries, starting at entry 1 and wrapping from the last entry back to entry 0: {1,0xBC}, {1,0xFB}, {0,0x00}…{0,0xFF}, then with the flag set 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xDC, 0xFC, 0xF7, 0xFE, 0xFD. The list position advances on every judged word, whether it matched or not.
- R7: A judged word that mismatches sets `err_pulse` for exactly the cycle after its accepting edge and adds one to `err_count`.
- R8: `err_count` saturates at its all-ones value. While saturated, `err_pulse` still fires. `clear` sets the count to 0 at the next edge and wins over an increment on the same edge.
- R9: Sixteen consecutive mismatched judged words drop `locked` at the edge that accepts the sixteenth. A matching word restarts the run. The search then resumes with the next accepted word.
- R10: In modes 2 and 3, word bits above bit 8 are ignored when comparing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received word is present |
| in_ready | output | 1 | Always 1; the checker never stalls |
| in_word | input | W | Received word, bit 0 earliest |
| mode | input | 2 | 0 short PRBS, 1 long PRBS, 2/3 byte list |
| clear | input | 1 | Synchronous clear of the error count |
| locked | output | 1 | Alignment found and reference running |
| err_pulse | output | 1 | One-cycle flag for a mismatched word |
| err_count | output | CNT_W | Saturating count of mismatched words |

## Verification
Each result has a fixed due cycle. In the shift-register modes, lock and the verdict on an aligned word fall at the edge that accepts the word two after the one holding their first bit. In the byte-list mode, both fall at the edge that accepts the word itself. The bench drives each word 2 ns after a rising edge and samples all outputs 2 ns after the edge that accepts it. It computes the due word index from the bit position where it placed the marker or a flipped bit, and checks lock and the error flag against that index on every word. Saturation is checked with a narrow counter parameter so that it is reached in a few dozen words.

// File: rtl/bpc_pkg.sv
`timescale 1ns/1ps
package bpc_pkg;
  localparam int LFSR_MAX  = 10;
  localparam int SEQ_LEN   = 268;
  localparam int MARK8_LEN = 16;
  localparam int MARK10_LEN = 10;
  localparam logic [15:0] MARK8 = 16'hFF01;   // bit 0 = first received
  localparam logic [8:0]  SYNC_WORD = 9'h1BC;

  typedef enum logic [1:0] {ST_HUNT, ST_SEED, ST_RUN} chk_state_t;

  // one entry of the repeating control/data list: {flag, byte}
  function automatic logic [8:0] list_code(input logic [8:0] pos);
    logic [8:0] d;
    logic [8:0] t;
    d = pos - 9'd2;
    t = pos - 9'd258;
    if (pos == 9'd0) return 9'h1BC;
    if (pos == 9'd1) return 9'h1FB;
    if (pos < 9'd258) return {1'b0, d[7:0]};
    case (t)
      9'd0:    return 9'h11C;
      9'd1:    return 9'h13C;
      9'd2:    return 9'h15C;
      9'd3:    return 9'h17C;
      9'd4:    return 9'h19C;
      9'd5:    return 9'h1DC;
      9'd6:    return 9'h1FC;
      9'd7:    return 9'h1F7;
      9'd8:    return 9'h1FE;
      default: return 9'h1FD;
    endcase
  endfunction
endpackage

// File: rtl/bpc_window.sv
`timescale 1ns/1ps
module bpc_window import bpc_pkg::*; #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         long_mode,
  input  logic [W-1:0] in_word,
  input  logic         capture,
  output logic         hit,
  output logic [1:0]   hit_skip,
  output logic [W-1:0] aligned
);
  localparam int OFF_W = $clog2(W);

  logic [W-1:0]     w1, w2;
  logic [1:0]       fill;
  logic [OFF_W-1:0] aoff, aoff_nx;
  logic [3*W-1:0]   win;

  assign win = {in_word, w1, w2};

  always_comb begin
    int e;
    hit = 1'b0;
    e   = 0;
    for (int o = W - 1; o >= 0; o--) begin
      if (fill == 2'd2) begin
        if (long_mode ? (&win[o +: MARK10_LEN]) : (win[o +: MARK8_LEN] == MARK8)) begin
          hit = 1'b1;
          e   = o + (long_mode ? MARK10_LEN : MARK8_LEN);
        end
      end
    end
    hit_skip = 2'(e / W);
    aoff_nx  = OFF_W'(e % W);
  end

  assign aligned = win[aoff +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1   <= '0;
      w2   <= '0;
      fill <= '0;
      aoff <= '0;
    end else begin
      if (valid) begin
        w2 <= w1;
        w1 <= in_word;
        if (fill != 2'd2) fill <= fill + 2'd1;
      end
      if (capture) aoff <= aoff_nx;
    end
  end
endmodule

// File: rtl/bpc_ref.sv
`timescale 1ns/1ps
module bpc_ref import bpc_pkg::*; #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         short_mode,
  input  logic         list_mode,
  input  logic         seed_en,
  input  logic [W-1:0] seed_word,
  input  logic         list_start,
  input  logic         adv,
  output logic [W-1:0] exp_word
);
  logic [LFSR_MAX-1:0]   st, st_seed;
  logic [8:0]            pos;
  logic [W+LFSR_MAX-1:0] run;

  function automatic logic [W+LFSR_MAX-1:0] step_word(input logic [LFSR_MAX-1:0] s0,
                                                      input logic short_m);
    logic [LFSR_MAX-1:0] s;
    logic [W-1:0] b;
    logic nb;
    s = s0;
    b = '0;
    for (int i = 0; i < W; i++) begin
      nb   = short_m ? (s[0] ^ s[2] ^ s[4] ^ s[7]) : (s[2] ^ s[9]);
      b[i] = nb;
      s    = {s[LFSR_MAX-2:0], nb};
    end
    return {s, b};
  endfunction

  assign run = step_word(st, short_mode);

  always_comb begin
    for (int k = 0; k < LFSR_MAX; k++) st_seed[k] = seed_word[W-1-k];
  end

  assign exp_word = list_mode ? {{(W-9){1'b0}}, list_code(pos)} : run[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      pos <= '0;
    end else begin
      if (seed_en)     st <= st_seed;
      else if (adv)    st <= run[W+LFSR_MAX-1:W];
      if (list_start)  pos <= 9'd1;
      else if (adv)    pos <= (pos == 9'(SEQ_LEN - 1)) ? 9'd0 : pos + 9'd1;
    end
  end
endmodule

// File: rtl/bpc_err.sv
`timescale 1ns/1ps
module bpc_err #(
  parameter int CNT_W    = 16,
  parameter int LOSS_RUN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             judge,
  input  logic             mismatch,
  input  logic             clear,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count,
  output logic             lose
);
  localparam int RUN_W = $clog2(LOSS_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [RUN_W-1:0] run;
  logic             bad;

  assign bad  = judge && mismatch;
  assign lose = bad && (run == RUN_W'(LOSS_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_count <= '0;
      run       <= '0;
    end else begin
      err_pulse <= bad;
      if (clear)                          err_count <= '0;
      else if (bad && err_count != CNT_MAX) err_count <= err_count + 1'b1;
      if (judge) run <= (!mismatch || lose) ? '0 : run + 1'b1;
    end
  end

  a_r8_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !clear) |=> err_count == CNT_MAX);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> err_count == '0);
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));
endmodule

// File: rtl/bist_pattern_checker.sv
`timescale 1ns/1ps
module bist_pattern_checker import bpc_pkg::*; #(
  parameter int W        = 10,
  parameter int CNT_W    = 16,
  parameter int LOSS_RUN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_word,
  input  logic [1:0]       mode,
  input  logic             clear,
  output logic             locked,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);
  chk_state_t state;
  logic [1:0] skip_cnt;
  logic       list_mode, hit, capture, seed_en, list_start, judge, mismatch, lose;
  logic [1:0] hit_skip;
  logic [W-1:0] aligned, exp_word, cmp_word;

  assign in_ready  = 1'b1;
  assign list_mode = mode[1];
  assign locked    = (state != ST_HUNT);

  assign capture    = in_valid && state == ST_HUNT && !list_mode && hit;
  assign list_start = in_valid && state == ST_HUNT && list_mode && in_word[8:0] == SYNC_WORD;
  assign seed_en    = in_valid && state == ST_SEED && skip_cnt == 2'd1;
  assign judge      = in_valid && state == ST_RUN;
  assign cmp_word   = list_mode ? {{(W-9){1'b0}}, in_word[8:0]} : aligned;
  assign mismatch   = cmp_word != exp_word;

  bpc_window #(.W(W)) u_win (
    .clk, .rst_n, .valid(in_valid), .long_mode(mode == 2'd1), .in_word,
    .capture, .hit, .hit_skip, .aligned
  );

  bpc_ref #(.W(W)) u_ref (
    .clk, .rst_n, .short_mode(mode == 2'd0), .list_mode, .seed_en,
    .seed_word(aligned), .list_start, .adv(judge), .exp_word
  );

  bpc_err #(.CNT_W(CNT_W), .LOSS_RUN(LOSS_RUN)) u_err (
    .clk, .rst_n, .judge, .mismatch, .clear, .err_pulse, .err_count, .lose
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      skip_cnt <= '0;
    end else if (in_valid) begin
      case (state)
        ST_HUNT: begin
          if (list_start) state <= ST_RUN;
          else if (capture) begin
            state    <= ST_SEED;
            skip_cnt <= hit_skip;
          end
        end
        ST_SEED: begin
          if (seed_en) state <= ST_RUN;
          else         skip_cnt <= skip_cnt - 2'd1;
        end
        default: if (lose) state <= ST_HUNT;
      endcase
    end
  end

  a_r7_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(locked) && $past(in_valid)));
  a_r9_drop_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> !locked);
  a_r6_sync_locks: assert property (@(posedge clk) disable iff (!rst_n)
    list_start |=> locked);
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!err_pulse && $stable(locked)));
endmodule

// File: tb/bist_pattern_checker_test.sv
`timescale 1ns/1ps
module bist_pattern_checker_test;
  localparam int W = 10;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_word = '0;
  logic [1:0] mode = 2'd2;
  logic clear = 1'b0;
  logic locked, err_pulse;
  logic [CW-1:0] err_count;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bist_pattern_checker #(.W(W), .CNT_W(CW), .LOSS_RUN(16)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_word, .mode, .clear,
    .locked, .err_pulse, .err_count
  );

  // rows: {valid, clear, word[9:0], exp_locked, exp_err, exp_count[7:0]}
  localparam int NROW = 14;
  localparam logic [21:0] TBL [NROW] = '{
    {1'b1, 1'b0, 10'h005, 1'b0, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h1BC, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h1FB, 1'b1, 1'b0, 8'd0},
    {1'b0, 1'b0, 10'h0AA, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h000, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h001, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h202, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h005, 1'b1, 1'b1, 8'd1},
    {1'b1, 1'b0, 10'h004, 1'b1, 1'b0, 8'd1},
    {1'b1, 1'b0, 10'h105, 1'b1, 1'b1, 8'd2},
    {1'b0, 1'b0, 10'h000, 1'b1, 1'b0, 8'd2},
    {1'b1, 1'b0, 10'h006, 1'b1, 1'b0, 8'd2},
    {1'b1, 1'b1, 10'h007, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b0, 10'h1BC, 1'b1, 1'b1, 8'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [W-1:0] w, input logic c);
    in_valid = v;
    in_word  = w;
    clear    = c;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    clear    = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    mode  = m;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  function automatic logic [8:0] ref_code(input int j);
    if (j == 0) return 9'h1BC;
    if (j == 1) return 9'h1FB;
    if (j < 258) return {1'b0, 8'(j - 2)};
    case (j - 258)
      0: return 9'h11C;
      1: return 9'h13C;
      2: return 9'h15C;
      3: return 9'h17C;
      4: return 9'h19C;
      5: return 9'h1DC;
      6: return 9'h1FC;
      7: return 9'h1F7;
      8: return 9'h1FE;
      default: return 9'h1FD;
    endcase
  endfunction

  task automatic run_prbs(input bit short_m, input int pre, input bit flip, input string tag);
    bit bs [400];
    int plen, m, kl, ke, f;
    logic [W-1:0] w;
    plen = short_m ? 16 : 10;
    do_reset(short_m ? 2'd0 : 2'd1);
    foreach (bs[i]) bs[i] = 1'b0;
    for (int i = 0; i < plen; i++)
      bs[pre + i] = short_m ? ((i == 0) || (i >= 8)) : 1'b1;
    m = pre + plen;
    for (int i = 0; i < 10; i++) bs[m + i] = ((10'b1011001110 >> i) & 1) != 0;
    for (int n = m + 10; n < 400; n++)
      bs[n] = short_m ? (bs[n-1] ^ bs[n-3] ^ bs[n-5] ^ bs[n-8]) : (bs[n-3] ^ bs[n-10]);
    f = m + 5 * W + 3;
    if (flip) bs[f] = ~bs[f];
    kl = pre / W + 2;
    ke = m / W + 2 + 5;
    for (int k = 0; k < 36; k++) begin
      for (int i = 0; i < W; i++) w[i] = bs[k * W + i];
      push(1'b1, w, 1'b0);
      chk({tag, " R3 R4 lock timing"}, int'(locked), int'(k >= kl));
      chk({tag, " R5 R7 error flag"}, int'(err_pulse), int'(flip && k == ke));
    end
    chk({tag, " R5 R7 final count"}, int'(err_count), flip ? 1 : 0);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pos, nbad;
    logic [21:0] row;
    // reset state, R2
    do_reset(2'd2);
    chk("R2 locked after reset", int'(locked), 0);
    chk("R2 err_pulse after reset", int'(err_pulse), 0);
    chk("R2 count after reset", int'(err_count), 0);
    chk("R1 ready", int'(in_ready), 1);

    // table walk: R1 R6 R7 R8 R10
    for (int r = 0; r < NROW; r++) begin
      row = TBL[r];
      push(row[21], row[19:10], row[20]);
      chk($sformatf("R6 R7 table row %0d locked", r), int'(locked), int'(row[9]));
      chk($sformatf("R1 R7 R10 table row %0d err", r), int'(err_pulse), int'(row[8]));
      chk($sformatf("R7 R8 table row %0d count", r), int'(err_count), int'(row[7:0]));
    end

    // full list twice with wrap, R6
    do_reset(2'd2);
    push(1'b1, 10'h1BC, 1'b0);
    chk("R6 lock on sync", int'(locked), 1);
    for (int j = 1; j <= 2 * 268; j++) begin
      push(1'b1, {1'b0, ref_code(j % 268)}, 1'b0);
      chk($sformatf("R6 list word %0d", j), int'(err_pulse), 0);
    end
    chk("R6 list locked", int'(locked), 1);
    chk("R6 list count", int'(err_count), 0);

    // loss of lock and saturation, R9 R8 (mode 3)
    do_reset(2'd3);
    push(1'b1, 10'h1BC, 1'b0);
    pos = 1;
    nbad = 0;
    for (int i = 0; i < 31; i++) begin
      if (i == 15) push(1'b1, {1'b0, ref_code(pos)}, 1'b0);
      else begin
        push(1'b1, {1'b0, ref_code(pos) ^ 9'h001}, 1'b0);
        nbad++;
      end
      pos = (pos + 1) % 268;
      chk($sformatf("R9 lock held word %0d", i), int'(locked), 1);
    end
    push(1'b1, {1'b0, ref_code(pos) ^ 9'h001}, 1'b0);
    nbad++;
    chk("R9 lock dropped on sixteenth", int'(locked), 0);
    chk("R8 count at max", int'(err_count), 31);
    chk("R9 total bad words", nbad, 31);
    push(1'b1, 10'h1BC, 1'b0);
    chk("R9 relock after drop", int'(locked), 1);
    for (int i = 0; i < 3; i++) begin
      push(1'b1, 10'h0EE, 1'b0);
      chk("R8 pulse while saturated", int'(err_pulse), 1);
      chk("R8 count saturated", int'(err_count), 31);
    end
    push(1'b0, 10'h000, 1'b1);
    chk("R8 clear", int'(err_count), 0);

    // shift-register modes at several offsets, R3 R4 R5
    run_prbs(1'b1, 13, 1'b0, "short off3");
    run_prbs(1'b1, 27, 1'b1, "short off7");
    run_prbs(1'b0, 4, 1'b1, "long off4");
    run_prbs(1'b0, 39, 1'b0, "long off9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule